// File: doc/BRIEF.md
# Masked Base-Address Chip Select Decoder

This block turns a 32-bit memory transaction address into four active-low chip selects that cover one programmable window in the middle of the address space. Software loads a 10-bit base and a 10-bit compare mask for address bits 23 down to 14 through a small byte-wide register port. A transaction lands in the window when the top address byte is zero, the master enable is set, and every address bit whose mask bit is set equals the corresponding base bit. The window is then cut into four equal quarters, and exactly one select goes active for the quarter that was hit.

Refresh cycles are handled separately. Each select has its own refresh enable, and during a refresh transaction the enabled selects go active whatever the master enable and the address. A scheme input picks an alternate decoding arrangement: while it is set, this logic drives no select at all and the base and mask have no effect. All selects are registered, so they follow the inputs sampled on the previous rising clock edge.

Top module: `midwin_cs_decoder`

## Requirements
- R1: While and after reset, `cs_n` is 4'b1111 and all four configuration registers read back as zero.
- R2: A write with `cfg_wr` high stores `cfg_wdata` on the rising edge into the register picked by `cfg_sel`: 0 holds base bits 23..16 in data bits 7..0, 1 holds base bits 15..14 in data bits 1..0, 2 holds mask bits 23..16 in data bits 7..0, 3 holds mask bits 15..14 in data bits 1..0. `cfg_rdata` shows the picked register combinationally, unused data bits reading zero.
- R3: In a non-refresh request, any set bit among address bits 31..24 keeps all selects inactive.
- R4: In a non-refresh request, `mid_en` low keeps all selects inactive.
- R5: Address bits 23..14 whose mask bit is 1 must equal the base bit for a select to fire; bits whose mask bit is 0 are not compared.
- R6: Let L be the position of the lowest set mask bit among 23..14, or 24 when the mask is zero. On a hit, if L is 16 or more, select number {addr[L-1], addr[L-2]} goes active; otherwise select 0 does. Exactly one select is active for a non-refresh hit.
- R7: In a request with `rfsh` high and `scheme_alt` low, select i is active exactly when `rfsh_en[i]` is 1, regardless of `mid_en`, the address and the registers.
- R8: While `scheme_alt` is high, no select goes active, refresh included.
- R9: While `mreq` is low, no select goes active.
- R10: `cs_n` changes only on a rising clock edge and reflects the inputs and registers sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | input | 32 | Transaction address |
| mreq | input | 1 | Memory request strobe, active high |
| rfsh | input | 1 | Refresh transaction indicator |
| scheme_alt | input | 1 | Alternate decoding scheme selected; disables this logic |
| mid_en | input | 1 | Master enable for window selects |
| rfsh_en | input | 4 | Per-select refresh enables |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and read |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| cs_n | output | 4 | Window chip selects, active low, registered |

## Verification
The bound checker watches on every cycle that an idle strobe, the alternate scheme, a nonzero top byte or a cleared master enable leave every select high, that a non-refresh request never drives more than one select low, that refresh selects mirror the refresh enables, and that reset forces the selects high. What only the bench can show is which select is right: the masked comparison against the base, the quarter chosen from the bits below the lowest mask bit for contiguous and scattered masks, the fallback to select 0 when too few free bits remain, and the register encoding seen through readback. The bench sweeps every contiguous mask width plus several irregular masks across several bases and many addresses, comparing against an arithmetic model.

// File: rtl/midwin_pkg.sv
package midwin_pkg;

    localparam int ADDR_W  = 32;
    localparam int WIN_HI  = 23;
    localparam int WIN_LO  = 14;
    localparam int WIN_W   = WIN_HI - WIN_LO + 1;
    localparam int TOP_W   = ADDR_W - WIN_HI - 1;
    localparam int CFG_W   = 8;
    localparam int LO_W    = WIN_W - CFG_W;
    localparam int NUM_CS  = 4;
    localparam int QSEL_W  = $clog2(NUM_CS);
    localparam int POS_W   = $clog2(WIN_W + 1);

    typedef enum logic [1:0] {
        CFG_BASE_HI = 2'd0,
        CFG_BASE_LO = 2'd1,
        CFG_MASK_HI = 2'd2,
        CFG_MASK_LO = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [WIN_W-1:0] base;
        logic [WIN_W-1:0] mask;
    } win_cfg_t;

    // Position (window-relative) of the lowest set mask bit, WIN_W if none.
    function automatic logic [POS_W-1:0] low_mask_pos(input logic [WIN_W-1:0] m);
        logic [POS_W-1:0] pos;
        pos = POS_W'(WIN_W);
        for (int i = WIN_W - 1; i >= 0; i--) begin
            if (m[i]) pos = POS_W'(i);
        end
        return pos;
    endfunction

    // Quarter index from the two window bits below pos; zero if fewer than two.
    function automatic logic [QSEL_W-1:0] quarter_of(input logic [WIN_W-1:0] w,
                                                     input logic [POS_W-1:0] pos);
        logic [QSEL_W-1:0] q;
        q = '0;
        for (int i = QSEL_W; i <= WIN_W; i++) begin
            if (pos == POS_W'(i)) q = {w[i-1], w[i-2]};
        end
        return q;
    endfunction

endpackage

// File: rtl/midwin_regs.sv
module midwin_regs
    import midwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  cfg_sel_e          sel_i,
    input  logic [CFG_W-1:0]  wdata_i,
    output logic [CFG_W-1:0]  rdata_o,
    output win_cfg_t          cfg_o
);

    win_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_i) begin
            case (sel_i)
                CFG_BASE_HI: cfg_q.base[WIN_W-1:LO_W] <= wdata_i;
                CFG_BASE_LO: cfg_q.base[LO_W-1:0]     <= wdata_i[LO_W-1:0];
                CFG_MASK_HI: cfg_q.mask[WIN_W-1:LO_W] <= wdata_i;
                CFG_MASK_LO: cfg_q.mask[LO_W-1:0]     <= wdata_i[LO_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel_i)
            CFG_BASE_HI: rdata_o = cfg_q.base[WIN_W-1:LO_W];
            CFG_BASE_LO: rdata_o[LO_W-1:0] = cfg_q.base[LO_W-1:0];
            CFG_MASK_HI: rdata_o = cfg_q.mask[WIN_W-1:LO_W];
            CFG_MASK_LO: rdata_o[LO_W-1:0] = cfg_q.mask[LO_W-1:0];
            default: rdata_o = '0;
        endcase
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/midwin_match.sv
module midwin_match
    import midwin_pkg::*;
(
    input  logic [ADDR_W-WIN_LO-1:0] addr_i,
    input  win_cfg_t                 cfg_i,
    input  logic                     en_i,
    output logic [NUM_CS-1:0]        dec_o
);

    logic [TOP_W-1:0]  top_bits;
    logic [WIN_W-1:0]  win_bits;
    logic [POS_W-1:0]  low_pos;
    logic [QSEL_W-1:0] quarter;
    logic              hit;

    assign top_bits = addr_i[ADDR_W-WIN_LO-1:WIN_W];
    assign win_bits = addr_i[WIN_W-1:0];

    always_comb begin
        low_pos = low_mask_pos(cfg_i.mask);
        quarter = quarter_of(win_bits, low_pos);
        hit     = en_i && (top_bits == '0) &&
                  (((win_bits ^ cfg_i.base) & cfg_i.mask) == '0);
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_dec
        assign dec_o[g] = hit && (quarter == QSEL_W'(g));
    end

endmodule

// File: rtl/midwin_out.sv
module midwin_out
    import midwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mreq_i,
    input  logic              rfsh_i,
    input  logic              alt_i,
    input  logic [NUM_CS-1:0] rfsh_en_i,
    input  logic [NUM_CS-1:0] dec_i,
    output logic [NUM_CS-1:0] cs_n_o
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        logic act;
        assign act = mreq_i && !alt_i && (rfsh_i ? rfsh_en_i[g] : dec_i[g]);

        always_ff @(posedge clk) begin
            if (rst) cs_n_o[g] <= 1'b1;
            else     cs_n_o[g] <= !act;
        end
    end

endmodule

// File: rtl/midwin_cs_decoder.sv
module midwin_cs_decoder
    import midwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       mem_addr,
    input  logic              mreq,
    input  logic              rfsh,
    input  logic              scheme_alt,
    input  logic              mid_en,
    input  logic [3:0]        rfsh_en,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic [3:0]        cs_n
);

    win_cfg_t          cfg;
    logic [NUM_CS-1:0] dec;

    midwin_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (cfg_wr),
        .sel_i   (cfg_sel_e'(cfg_sel)),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .cfg_o   (cfg)
    );

    midwin_match u_match (
        .addr_i (mem_addr[ADDR_W-1:WIN_LO]),
        .cfg_i  (cfg),
        .en_i   (mid_en),
        .dec_o  (dec)
    );

    midwin_out u_out (
        .clk       (clk),
        .rst       (rst),
        .mreq_i    (mreq),
        .rfsh_i    (rfsh),
        .alt_i     (scheme_alt),
        .rfsh_en_i (rfsh_en),
        .dec_i     (dec),
        .cs_n_o    (cs_n)
    );

endmodule

// File: rtl/midwin_cs_decoder_chk.sv
module midwin_cs_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] mem_addr,
    input logic        mreq,
    input logic        rfsh,
    input logic        scheme_alt,
    input logic        mid_en,
    input logic [3:0]  rfsh_en,
    input logic [3:0]  cs_n
);

    assert_reset_high_R1: assert property (@(posedge clk)
        rst |=> (cs_n == 4'b1111));

    assert_top_byte_R3: assert property (@(posedge clk) disable iff (rst)
        (mreq && !rfsh && (mem_addr[31:24] != 8'h00)) |=> (cs_n == 4'b1111));

    assert_master_off_R4: assert property (@(posedge clk) disable iff (rst)
        (mreq && !rfsh && !mid_en) |=> (cs_n == 4'b1111));

    assert_single_select_R6: assert property (@(posedge clk) disable iff (rst)
        (mreq && !rfsh) |=> $onehot0(~cs_n));

    assert_refresh_mirror_R7: assert property (@(posedge clk) disable iff (rst)
        (mreq && rfsh && !scheme_alt) |=> (~cs_n == $past(rfsh_en)));

    assert_alt_scheme_R8: assert property (@(posedge clk) disable iff (rst)
        scheme_alt |=> (cs_n == 4'b1111));

    assert_idle_high_R9: assert property (@(posedge clk) disable iff (rst)
        !mreq |=> (cs_n == 4'b1111));

endmodule

bind midwin_cs_decoder midwin_cs_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mreq       (mreq),
    .rfsh       (rfsh),
    .scheme_alt (scheme_alt),
    .mid_en     (mid_en),
    .rfsh_en    (rfsh_en),
    .cs_n       (cs_n)
);

// File: tb/midwin_cs_decoder_tb.sv
module midwin_cs_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr = '0;
    logic        mreq = 1'b0;
    logic        rfsh = 1'b0;
    logic        scheme_alt = 1'b0;
    logic        mid_en = 1'b0;
    logic [3:0]  rfsh_en = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [3:0]  cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    midwin_cs_decoder u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mreq(mreq), .rfsh(rfsh),
        .scheme_alt(scheme_alt), .mid_en(mid_en), .rfsh_en(rfsh_en),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cs_n(cs_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Arithmetic reference: active-high select vector.
    function automatic logic [3:0] model(input logic [31:0] a, input logic [9:0] b,
                                         input logic [9:0] m, input logic rq,
                                         input logic rf, input logic alt,
                                         input logic en, input logic [3:0] ren);
        int low;
        int q;
        if (!rq || alt) return 4'b0000;
        if (rf) return ren;
        if (!en || a[31:24] != 8'h00) return 4'b0000;
        for (int i = 0; i < 10; i++)
            if (m[i] && (a[14+i] != b[i])) return 4'b0000;
        low = 24;
        for (int i = 9; i >= 0; i--) if (m[i]) low = 14 + i;
        q = (low >= 16) ? int'((a >> (low - 2)) & 32'd3) : 0;
        return 4'(1 << q);
    endfunction

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        cfg_sel = s; cfg_wdata = d; cfg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_cfg(input logic [9:0] b, input logic [9:0] m);
        wr(2'd0, b[9:2]); wr(2'd1, {6'h15, b[1:0]});
        wr(2'd2, m[9:2]); wr(2'd3, {6'h2A, m[1:0]});
        cfg_sel = 2'd0; #1 check("R2 base hi readback", cfg_rdata, b[9:2]);
        cfg_sel = 2'd1; #1 check("R2 base lo readback", cfg_rdata, {6'h0, b[1:0]});
        cfg_sel = 2'd2; #1 check("R2 mask hi readback", cfg_rdata, m[9:2]);
        cfg_sel = 2'd3; #1 check("R2 mask lo readback", cfg_rdata, {6'h0, m[1:0]});
    endtask

    task automatic step(input logic [9:0] b, input logic [9:0] m);
        logic [3:0] e;
        string tag;
        e = model(mem_addr, b, m, mreq, rfsh, scheme_alt, mid_en, rfsh_en);
        if (!mreq) tag = "R9 idle strobe";
        else if (scheme_alt) tag = "R8 alternate scheme";
        else if (rfsh) tag = "R7 refresh";
        else if (!mid_en) tag = "R4 master enable";
        else if (mem_addr[31:24] != 8'h00) tag = "R3 top byte";
        else if (e != 0) tag = "R6 quarter select";
        else tag = "R5 masked compare";
        @(posedge clk); @(negedge clk);
        check(tag, {4'h0, cs_n}, {4'h0, ~e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [9:0] masks [14];
        logic [9:0] bases [3];
        for (int k = 0; k <= 10; k++) masks[k] = 10'(((1 << k) - 1) << (10 - k));
        masks[11] = 10'b1010000000;
        masks[12] = 10'b0000000001;
        masks[13] = 10'b0100110000;
        bases[0] = 10'h000; bases[1] = 10'h2A5; bases[2] = 10'h3FF;

        // R1: reset state
        mreq = 1'b1; mid_en = 1'b1; rfsh = 1'b1; rfsh_en = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 selects in reset", {4'h0, cs_n}, 8'h0F);
        rst = 1'b0; mreq = 1'b0; rfsh = 1'b0;
        for (int s = 0; s < 4; s++) begin
            cfg_sel = 2'(s); #1 check("R1 register reset value", cfg_rdata, 8'h00);
        end

        // R10: output holds until the edge, then follows
        load_cfg(10'h000, 10'h000);
        mem_addr = 32'h00C0_0000; mreq = 1'b1; mid_en = 1'b1;
        #2 check("R10 no change before edge", {4'h0, cs_n}, 8'h0F);
        @(posedge clk); #1 check("R10 change after edge", {4'h0, cs_n}, 8'h07);
        @(negedge clk);

        // R6 fallback: mask reaching bit 15 leaves fewer than two free bits
        load_cfg(10'h155, 10'h3FE);
        mem_addr = {8'h00, 10'h155, 14'h0}; mem_addr[14] = 1'b1;
        step(10'h155, 10'h3FE);
        check("R6 fallback to select 0", {4'h0, cs_n}, 8'h0E);

        // Sweep
        for (int mi = 0; mi < 14; mi++) begin
            for (int bi = 0; bi < 3; bi++) begin
                load_cfg(bases[bi], masks[mi]);
                for (int n = 0; n < 24; n++) begin
                    logic [31:0] a;
                    logic [9:0] w;
                    w = (10'($urandom) & ~masks[mi]) | (bases[bi] & masks[mi]);
                    if (n % 4 == 1) w = w ^ 10'(1 << ($urandom % 10));
                    a = {8'h00, w, 14'($urandom)};
                    if (n % 8 == 5) a[31:24] = 8'($urandom | 1);
                    mem_addr = a;
                    mreq       = (n % 11 != 3);
                    mid_en     = (n % 7 != 2);
                    scheme_alt = (n % 13 == 6);
                    rfsh       = (n % 9 == 4);
                    rfsh_en    = 4'($urandom);
                    step(bases[bi], masks[mi]);
                end
            end
        end

        // R7: refresh ignores master enable and address
        mreq = 1'b1; rfsh = 1'b1; scheme_alt = 1'b0; mid_en = 1'b0;
        mem_addr = 32'hFFFF_FFFF; rfsh_en = 4'b1010;
        step(10'h3FF, 10'b0100110000);
        check("R7 refresh pattern", {4'h0, cs_n}, 8'h05);
        // R8: alternate scheme blocks refresh too
        scheme_alt = 1'b1; rfsh_en = 4'hF;
        step(10'h3FF, 10'b0100110000);
        check("R8 alternate blocks refresh", {4'h0, cs_n}, 8'h0F);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule